// File: doc/BRIEF.md
# Cascaded Interrupt Vector Acknowledge

This block sits between two eight-line priority units and the CPU's interrupt-acknowledge request. One unit is the primary, and the secondary unit's interrupt output is wired to primary request line 2. Each unit presents its winning line, a valid flag and its programmed vector base. When the CPU strobes an acknowledge, the block decides which unit owns the interrupt. It pulses an acknowledge to that unit, or to both units, with the line each one should mark as in service. It also returns an 8-bit vector with a done strobe.

If the primary winner is line 2, the request came through the cascade. Both units are then acknowledged and the vector comes from the secondary unit. Secondary lines correspond to system interrupt numbers 8 to 15. If no request survives at acknowledge time in the unit that would supply the vector, that unit's line 7 is substituted and the interrupt is treated as spurious. The vector is always formed from the upper five bits of the base with the 3-bit line below them.

Top module: `casc_ack_top`

## Requirements
- R1: While reset is held, and in the cycles after its release, `vec_done`, `mst_ack` and `slv_ack` are low.
- R2: An accepted strobe with `mst_valid`=1 and `mst_line`≠2 gives `vec` = {`mst_base`[7:3], `mst_line`}, pulses `mst_ack` with `mst_ack_line`=`mst_line`, and leaves `slv_ack` low.
- R3: An accepted strobe with `mst_valid`=1, `mst_line`=2 and `slv_valid`=1 gives `vec` = {`slv_base`[7:3], `slv_line`}. It pulses `mst_ack` with `mst_ack_line`=2 and pulses `slv_ack` with `slv_ack_line`=`slv_line`.
- R4: An accepted strobe with `mst_valid`=1, `mst_line`=2 and `slv_valid`=0 gives `vec` = {`slv_base`[7:3], 3'd7}. It pulses `mst_ack` with `mst_ack_line`=2 and leaves `slv_ack` low.
- R5: An accepted strobe with `mst_valid`=0 gives `vec` = {`mst_base`[7:3], 3'd7} and leaves both `mst_ack` and `slv_ack` low.
- R6: Bits 2:0 of `mst_base` and `slv_base` have no effect on `vec`.
- R7: `vec_done` and any acknowledge pulse are high in exactly the one cycle after the cycle in which the strobe is accepted. `vec` and the acknowledge lines are valid in that same cycle.
- R8: A strobe is accepted only when `vec_done` is low. A strobe arriving in the cycle where `vec_done` is high produces no further result, so a strobe held high for two cycles yields one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | CPU interrupt-acknowledge strobe |
| mst_valid | input | 1 | Primary unit has a surviving request |
| mst_line | input | 3 | Primary unit winning line |
| mst_base | input | 8 | Primary unit vector base |
| slv_valid | input | 1 | Secondary unit has a surviving request |
| slv_line | input | 3 | Secondary unit winning line |
| slv_base | input | 8 | Secondary unit vector base |
| mst_ack | output | 1 | Acknowledge pulse to primary unit |
| mst_ack_line | output | 3 | Line the primary unit marks in service |
| slv_ack | output | 1 | Acknowledge pulse to secondary unit |
| slv_ack_line | output | 3 | Line the secondary unit marks in service |
| vec | output | 8 | Interrupt vector |
| vec_done | output | 1 | Vector valid strobe |

## Verification
The block holds only its result registers and a done flag, so any wrong routing shows up in the single done cycle that follows the strobe. That includes a cascade taken on the wrong line, a missing spurious substitution, or base low bits leaking in. In that cycle it appears as a wrong vector or a missing or extra acknowledge pulse. A stuck done flag shows one cycle later as a second done pulse, or as a later strobe that never completes. The directed scenarios cover each path, and each one checks that cycle and the following one.

// File: rtl/casc_ack_pkg.sv
package casc_ack_pkg;
  localparam int CA_LINES  = 8;
  localparam int CA_LINE_W = $clog2(CA_LINES);
  localparam int CA_VEC_W  = 8;
  localparam logic [CA_LINE_W-1:0] CA_SPUR_LINE = CA_LINE_W'(CA_LINES - 1);

  typedef struct packed {
    logic                  mst_ack;
    logic [CA_LINE_W-1:0]  mst_line;
    logic                  slv_ack;
    logic [CA_LINE_W-1:0]  slv_line;
    logic [CA_VEC_W-1:0]   vec;
  } ack_res_t;
endpackage

// File: rtl/casc_rst_sync.sv
module casc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/casc_route.sv
module casc_route
  import casc_ack_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic                 mst_valid,
  input  logic [CA_LINE_W-1:0] mst_line,
  input  logic [CA_VEC_W-1:0]  mst_base,
  input  logic                 slv_valid,
  input  logic [CA_LINE_W-1:0] slv_line,
  input  logic [CA_VEC_W-1:0]  slv_base,
  output ack_res_t             res
);
  localparam logic [CA_LINE_W-1:0] CASC = CA_LINE_W'(CASCADE_LINE);

  logic via_slave;
  assign via_slave = mst_valid && (mst_line == CASC);

  always_comb begin
    res = '0;
    if (!mst_valid) begin
      res.vec = {mst_base[CA_VEC_W-1:CA_LINE_W], CA_SPUR_LINE};
    end else begin
      res.mst_ack  = 1'b1;
      res.mst_line = mst_line;
      if (via_slave) begin
        if (slv_valid) begin
          res.slv_ack  = 1'b1;
          res.slv_line = slv_line;
          res.vec      = {slv_base[CA_VEC_W-1:CA_LINE_W], slv_line};
        end else begin
          res.vec      = {slv_base[CA_VEC_W-1:CA_LINE_W], CA_SPUR_LINE};
        end
      end else begin
        res.vec = {mst_base[CA_VEC_W-1:CA_LINE_W], mst_line};
      end
    end
  end
endmodule

// File: rtl/casc_result_reg.sv
module casc_result_reg
  import casc_ack_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ack_req,
  input  ack_res_t res_d,
  output ack_res_t res_q,
  output logic     done_q
);
  logic     accept;
  logic     done_d;
  ack_res_t res_n;

  assign accept = ack_req && !done_q;

  always_comb begin
    done_d        = accept;
    res_n         = res_q;
    res_n.mst_ack = 1'b0;
    res_n.slv_ack = 1'b0;
    if (accept) res_n = res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= done_d;
      res_q  <= res_n;
    end
  end
endmodule

// File: rtl/casc_ack_top.sv
module casc_ack_top
  import casc_ack_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ack_req,
  input  logic                 mst_valid,
  input  logic [CA_LINE_W-1:0] mst_line,
  input  logic [CA_VEC_W-1:0]  mst_base,
  input  logic                 slv_valid,
  input  logic [CA_LINE_W-1:0] slv_line,
  input  logic [CA_VEC_W-1:0]  slv_base,
  output logic                 mst_ack,
  output logic [CA_LINE_W-1:0] mst_ack_line,
  output logic                 slv_ack,
  output logic [CA_LINE_W-1:0] slv_ack_line,
  output logic [CA_VEC_W-1:0]  vec,
  output logic                 vec_done
);
  logic     rst_int_n;
  ack_res_t route_res;
  ack_res_t held_res;

  casc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  casc_route #(.CASCADE_LINE(CASCADE_LINE)) u_route (
    .mst_valid(mst_valid), .mst_line(mst_line), .mst_base(mst_base),
    .slv_valid(slv_valid), .slv_line(slv_line), .slv_base(slv_base),
    .res(route_res)
  );

  casc_result_reg u_reg (
    .clk(clk), .rst_n(rst_int_n), .ack_req(ack_req),
    .res_d(route_res), .res_q(held_res), .done_q(vec_done)
  );

  assign mst_ack      = held_res.mst_ack;
  assign mst_ack_line = held_res.mst_line;
  assign slv_ack      = held_res.slv_ack;
  assign slv_ack_line = held_res.slv_line;
  assign vec          = held_res.vec;
endmodule

// File: rtl/casc_ack_checker.sv
module casc_ack_checker
  import casc_ack_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ack_req,
  input logic                 mst_ack,
  input logic [CA_LINE_W-1:0] mst_ack_line,
  input logic                 slv_ack,
  input logic [CA_LINE_W-1:0] slv_ack_line,
  input logic [CA_VEC_W-1:0]  vec,
  input logic                 vec_done
);
  assert_acks_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_ack || slv_ack) |-> vec_done);

  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !vec_done) |=> vec_done);

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |=> !vec_done);

  assert_slave_via_cascade_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slv_ack |-> (mst_ack && mst_ack_line == 3'd2 && vec[2:0] == slv_ack_line));

  assert_master_line_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_ack && mst_ack_line != 3'd2) |-> (!slv_ack && vec[2:0] == mst_ack_line));

  assert_cascade_spur_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_ack && mst_ack_line == 3'd2 && !slv_ack) |-> (vec[2:0] == 3'd7));

  assert_master_spur_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_done && !mst_ack) |-> (!slv_ack && vec[2:0] == 3'd7));
endmodule

bind casc_ack_top casc_ack_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
  .mst_ack(mst_ack), .mst_ack_line(mst_ack_line),
  .slv_ack(slv_ack), .slv_ack_line(slv_ack_line),
  .vec(vec), .vec_done(vec_done)
);

// File: tb/casc_ack_top_test.sv
module casc_ack_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ack_req;
  logic       mst_valid, slv_valid;
  logic [2:0] mst_line, slv_line;
  logic [7:0] mst_base, slv_base;
  logic       mst_ack, slv_ack, vec_done;
  logic [2:0] mst_ack_line, slv_ack_line;
  logic [7:0] vec;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  casc_ack_top uut (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
    .mst_valid(mst_valid), .mst_line(mst_line), .mst_base(mst_base),
    .slv_valid(slv_valid), .slv_line(slv_line), .slv_base(slv_base),
    .mst_ack(mst_ack), .mst_ack_line(mst_ack_line),
    .slv_ack(slv_ack), .slv_ack_line(slv_ack_line),
    .vec(vec), .vec_done(vec_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic mv, input logic [2:0] ml, input logic [7:0] mb,
                        input logic sv, input logic [2:0] sl, input logic [7:0] sb);
    mst_valid = mv; mst_line = ml; mst_base = mb;
    slv_valid = sv; slv_line = sl; slv_base = sb;
  endtask

  // One strobe; checks the done cycle and the cycle after.
  task automatic do_ack(input string req, input logic [7:0] ev,
                        input logic ema, input logic [2:0] eml,
                        input logic esa, input logic [2:0] esl);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
    chk({req, " done"}, int'(vec_done), 1);
    chk({req, " vec"}, int'(vec), int'(ev));
    chk({req, " mst_ack"}, int'(mst_ack), int'(ema));
    if (ema) chk({req, " mst_line"}, int'(mst_ack_line), int'(eml));
    chk({req, " slv_ack"}, int'(slv_ack), int'(esa));
    if (esa) chk({req, " slv_line"}, int'(slv_ack_line), int'(esl));
    @(negedge clk);
    chk("R7 pulse width done", int'(vec_done), 0);
    chk("R7 pulse width acks", int'(mst_ack | slv_ack), 0);
  endtask

  task automatic t_reset();
    chk("R1 done", int'(vec_done), 0);
    chk("R1 acks", int'(mst_ack | slv_ack), 0);
  endtask

  task automatic t_master();
    set_in(1, 3'd5, 8'h40, 1, 3'd3, 8'h70);
    do_ack("R2 line5", 8'h45, 1, 3'd5, 0, 3'd0);
    set_in(1, 3'd0, 8'h08, 0, 3'd0, 8'h70);
    do_ack("R2 line0", 8'h08, 1, 3'd0, 0, 3'd0);
  endtask

  task automatic t_cascade();
    set_in(1, 3'd2, 8'h08, 1, 3'd4, 8'h70);
    do_ack("R3 slave4", 8'h74, 1, 3'd2, 1, 3'd4);
    set_in(1, 3'd2, 8'h08, 1, 3'd0, 8'h70);
    do_ack("R3 slave0", 8'h70, 1, 3'd2, 1, 3'd0);
  endtask

  task automatic t_spurious();
    set_in(1, 3'd2, 8'h08, 0, 3'd4, 8'h70);
    do_ack("R4 cascade spur", 8'h77, 1, 3'd2, 0, 3'd0);
    set_in(0, 3'd3, 8'h20, 1, 3'd4, 8'h70);
    do_ack("R5 master spur", 8'h27, 0, 3'd0, 0, 3'd0);
  endtask

  task automatic t_base_low();
    set_in(1, 3'd1, 8'h46, 1, 3'd1, 8'h75);
    do_ack("R6 master base", 8'h41, 1, 3'd1, 0, 3'd0);
    set_in(1, 3'd2, 8'h0f, 1, 3'd6, 8'h7b);
    do_ack("R6 slave base", 8'h7e, 1, 3'd2, 1, 3'd6);
  endtask

  task automatic t_held_strobe();
    set_in(1, 3'd3, 8'h50, 0, 3'd0, 8'h70);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk);
    chk("R7 done after strobe", int'(vec_done), 1);
    chk("R7 vec", int'(vec), 8'h53);
    @(negedge clk); ack_req = 1'b0;
    chk("R8 held strobe ignored", int'(vec_done), 0);
    chk("R8 no ack", int'(mst_ack), 0);
    @(negedge clk);
    chk("R8 idle", int'(vec_done), 0);
  endtask

  initial begin
    ack_req = 1'b0;
    set_in(0, 3'd0, 8'h00, 0, 3'd0, 8'h00);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_master();
    t_cascade();
    t_spurious();
    t_base_low();
    t_held_strobe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule